// File: doc/BRIEF.md
# Dual-Channel Tick-Driven PWM Controller

This block produces two pulse-width-modulated outputs. Each channel counts ticks that an external frequency generator delivers, one tick input per channel. An 8-bit period value and an 8-bit high-time value set the waveform. A small register file, written over a simple byte-addressed port, holds the following:

- a shared control register with one 4-bit field per channel;
- a source-select register;
- a 16-bit generator control word per channel, which the block only stores and presents to the generator;
- the high-time and period values for each channel.

Each channel drives two pad signals: a pin value and an output enable. The channel's selected source is either its own PWM waveform or the generator's raw variable-frequency signal. Force-high, open-drain drive and an output disable shape that source before it reaches the pad.

High-time and period changes take effect only at the end of the current period, so a reprogramming never cuts a pulse short.

Top module: `dpwm_top`

## Requirements
- R1: After reset the control register at 0x00 reads 0x22 (both channels disabled), every other register reads 0, both `oe_o` bits are 0 and `cword_o` is 0.
- R2: Register offsets are: control 0x00, source select 0x04, control word high byte 0x08+8c, control word low byte 0x0C+8c, high time 0x18+8c, period 0x1C+8c (c = channel). Each stored value reads back. `cword_o[16c+15:16c]` equals {high byte, low byte}. Writes to any other offset are ignored and such offsets read 0.
- R3: Channel c owns bits 4c+3..4c of the control register: bit 0 run, bit 1 output disable, bit 2 force high, bit 3 open drain. In the source-select register only bit 4c is stored: 1 selects the PWM waveform and 0 selects `vf_i[c]`. The other bits read 0.
- R4: While run is set, the counter advances by one on each cycle with `tick_i[c]` high. A period spans period+1 ticks, and the waveform is high for the first "high time" ticks of each period.
- R5: When the high time exceeds the period (for example 0xFF with period 0xFE), the waveform stays high continuously.
- R6: When the high time is 0, the waveform stays low.
- R7: With run clear, the counter is held at 0 and the waveform is low. After run is set again, a new period starts with the current register values.
- R8: New high-time and period values take effect only when the running period wraps, or while the channel is stopped.
- R9: With the source bit at 0, the logical output follows `vf_i[c]` in the same cycle.
- R10: Force high sets the logical output to 1 whatever the source. It does not override the output disable.
- R11: In open-drain mode `pin_o[c]` is 0 and `oe_o[c]` is asserted only while the logical output is low.
- R12: With output disable set, `oe_o[c]` is 0 regardless of the other bits.
- R13: The two channels run independently from their own ticks and registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tick_i | input | 2 | Generator tick per channel |
| vf_i | input | 2 | Raw variable-frequency signal per channel |
| cword_o | output | 32 | Generator control word per channel, 16 bits each |
| pin_o | output | 2 | Pad output value per channel |
| oe_o | output | 2 | Pad output enable per channel |

## Verification
A register write lands on the clock edge that samples the strobe. Control, select and pad effects then appear on the outputs right after that edge, and read data follows the address combinationally in the same cycle. Waveform state moves one edge after a sampled tick, while `vf_i` reaches the pin with no register in between. The bench drives all inputs on the falling edge. Its behavioural model steps on the rising edge, and it compares pins, enables and control words 1 ns after each falling edge, once every output has settled for that cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int FIELD_W   = 4;
  localparam int CH_STRIDE = 8;
  localparam int ADR_CTRL  = 'h00;
  localparam int ADR_SEL   = 'h04;
  localparam int ADR_CW_HI = 'h08;
  localparam int ADR_CW_LO = 'h0C;
  localparam int ADR_ON    = 'h18;
  localparam int ADR_PER   = 'h1C;

  // bit order matches the control field layout
  typedef struct packed {
    logic odrain;
    logic force_hi;
    logic dis;
    logic run;
  } ch_ctrl_t;

  function automatic logic [31:0] dis_mask(int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i*FIELD_W+1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output ch_ctrl_t [NUM_CH-1:0]               ctrl_o,
  output logic [NUM_CH-1:0]                   pwm_sel_o,
  output logic [NUM_CH-1:0][2*DATA_W-1:0]     cword_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]        on_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]        per_o
);
  localparam int CTRL_W = NUM_CH * FIELD_W;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(dis_mask(NUM_CH));

  function automatic logic [ADDR_W-1:0] ch_addr(int base, int c);
    return ADDR_W'(base + c * CH_STRIDE);
  endfunction

  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_CH-1:0] sel_q;
  logic [NUM_CH-1:0][DATA_W-1:0] hi_q, lo_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  on_q, per_q;

  wire ctrl_hit = wr_en_i && (addr_i == ADDR_W'(ADR_CTRL));
  wire sel_hit  = wr_en_i && (addr_i == ADDR_W'(ADR_SEL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= CTRL_RST;
    else if (ctrl_hit) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wire hi_hit  = wr_en_i && (addr_i == ch_addr(ADR_CW_HI, c));
    wire lo_hit  = wr_en_i && (addr_i == ch_addr(ADR_CW_LO, c));
    wire on_hit  = wr_en_i && (addr_i == ch_addr(ADR_ON, c));
    wire per_hit = wr_en_i && (addr_i == ch_addr(ADR_PER, c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[c] <= 1'b0;
        hi_q[c]  <= '0;
        lo_q[c]  <= '0;
        on_q[c]  <= '0;
        per_q[c] <= '0;
      end else begin
        if (sel_hit) sel_q[c] <= wdata_i[c*FIELD_W];
        if (hi_hit)  hi_q[c]  <= wdata_i;
        if (lo_hit)  lo_q[c]  <= wdata_i;
        if (on_hit)  on_q[c]  <= wdata_i[CNT_W-1:0];
        if (per_hit) per_q[c] <= wdata_i[CNT_W-1:0];
      end
    end

    assign ctrl_o[c]    = ch_ctrl_t'(ctrl_q[c*FIELD_W +: FIELD_W]);
    assign pwm_sel_o[c] = sel_q[c];
    assign cword_o[c]   = {hi_q[c], lo_q[c]};
    assign on_o[c]      = on_q[c];
    assign per_o[c]     = per_q[c];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_CTRL)) rdata_o = DATA_W'(ctrl_q);
    if (addr_i == ADDR_W'(ADR_SEL)) begin
      for (int c = 0; c < NUM_CH; c++) rdata_o[c*FIELD_W] = sel_q[c];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ch_addr(ADR_CW_HI, c)) rdata_o = hi_q[c];
      if (addr_i == ch_addr(ADR_CW_LO, c)) rdata_o = lo_q[c];
      if (addr_i == ch_addr(ADR_ON, c))    rdata_o = DATA_W'(on_q[c]);
      if (addr_i == ch_addr(ADR_PER, c))   rdata_o = DATA_W'(per_q[c]);
    end
  end

  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit |=> ctrl_q == $past(wdata_i[CTRL_W-1:0]));
  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_hit |=> $stable(ctrl_q));
endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, on_act_q, per_act_q;

  wire wrap = (cnt_q == per_act_q);
  // shadow values reload at a period boundary or while stopped
  wire load = !run_i || (tick_i && wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      on_act_q  <= '0;
      per_act_q <= '0;
    end else begin
      if (!run_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (load) begin
        on_act_q  <= on_i;
        per_act_q <= per_i;
      end
    end
  end

  assign pwm_o = run_i && (cnt_q < on_act_q);

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_act_q);
  // R4
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_i |=> $stable(cnt_q));
  // R7
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !(tick_i && wrap) |=> $stable(on_act_q) && $stable(per_act_q));
  // R5
  full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (on_act_q > per_act_q) |-> pwm_o);
  // R6
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_act_q == '0 |-> !pwm_o);
endmodule

// File: rtl/dpwm_pad.sv
module dpwm_pad
  import dpwm_pkg::*;
(
  input  ch_ctrl_t ctrl_i,
  input  logic     sel_i,
  input  logic     pwm_i,
  input  logic     vf_i,
  output logic     pin_o,
  output logic     oe_o
);
  logic src, lvl;

  always_comb begin
    src   = sel_i ? pwm_i : vf_i;
    lvl   = ctrl_i.force_hi | src;
    // open drain: only ever pull low
    pin_o = !ctrl_i.odrain && lvl;
    oe_o  = !ctrl_i.dis && (!ctrl_i.odrain || !lvl);
  end
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_CH-1:0]          tick_i,
  input  logic [NUM_CH-1:0]          vf_i,
  output logic [NUM_CH*2*DATA_W-1:0] cword_o,
  output logic [NUM_CH-1:0]          pin_o,
  output logic [NUM_CH-1:0]          oe_o
);
  ch_ctrl_t [NUM_CH-1:0]               ctrl_w;
  logic [NUM_CH-1:0]                   sel_w, pwm_w;
  logic [NUM_CH-1:0][2*DATA_W-1:0]     cword_w;
  logic [NUM_CH-1:0][CNT_W-1:0]        on_w, per_w;

  dpwm_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .ctrl_o(ctrl_w), .pwm_sel_o(sel_w), .cword_o(cword_w),
    .on_o(on_w), .per_o(per_w)
  );

  assign cword_o = cword_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dpwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i, .rst_ni,
      .run_i (ctrl_w[c].run),
      .tick_i(tick_i[c]),
      .on_i  (on_w[c]),
      .per_i (per_w[c]),
      .pwm_o (pwm_w[c])
    );

    dpwm_pad u_pad (
      .ctrl_i(ctrl_w[c]),
      .sel_i (sel_w[c]),
      .pwm_i (pwm_w[c]),
      .vf_i  (vf_i[c]),
      .pin_o (pin_o[c]),
      .oe_o  (oe_o[c])
    );

    // R12
    dis_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_w[c].dis |-> !oe_o[c]);
    // R11
    od_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_w[c].odrain |-> !pin_o[c]);
    // R10
    force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_w[c].force_hi && !ctrl_w[c].odrain |-> pin_o[c]);
    // R7
    stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_w[c].run && sel_w[c] && !ctrl_w[c].force_hi && !ctrl_w[c].odrain
      |-> !pin_o[c]);
  end
endmodule

// File: tb/sim_dpwm_top.sv
`timescale 1ns/1ps
module sim_dpwm_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [1:0] tick = '0, vf = '0;
  wire  [7:0]  rdata;
  wire  [31:0] cword;
  wire  [1:0]  pin, oe;

  dpwm_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .vf_i(vf),
    .cword_o(cword), .pin_o(pin), .oe_o(oe)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  logic [7:0] m_ctrl = 8'h22, m_sel = 8'h00;
  logic [7:0] m_hi[2] = '{default: 8'h00}, m_lo[2] = '{default: 8'h00};
  logic [7:0] m_on[2] = '{default: 8'h00}, m_per[2] = '{default: 8'h00};
  int m_cnt[2] = '{default: 0}, m_aon[2] = '{default: 0}, m_aper[2] = '{default: 0};
  int tick_div[2] = '{default: 0}, tick_ph[2] = '{default: 0};
  int vf_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h22; m_sel = 8'h00;
      for (int c = 0; c < 2; c++) begin
        m_hi[c] = 0; m_lo[c] = 0; m_on[c] = 0; m_per[c] = 0;
        m_cnt[c] = 0; m_aon[c] = 0; m_aper[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (!m_ctrl[4*c]) begin
          m_cnt[c] = 0; m_aon[c] = m_on[c]; m_aper[c] = m_per[c];
        end else if (tick[c]) begin
          if (m_cnt[c] == m_aper[c]) begin
            m_cnt[c] = 0; m_aon[c] = m_on[c]; m_aper[c] = m_per[c];
          end else m_cnt[c]++;
        end
      end
      if (wr_en) begin
        case (addr)
          6'h00: m_ctrl = wdata;
          6'h04: m_sel = wdata & 8'h11;
          6'h08: m_hi[0] = wdata;
          6'h0C: m_lo[0] = wdata;
          6'h10: m_hi[1] = wdata;
          6'h14: m_lo[1] = wdata;
          6'h18: m_on[0] = wdata;
          6'h1C: m_per[0] = wdata;
          6'h20: m_on[1] = wdata;
          6'h24: m_per[1] = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic exp_lvl(int c);
    logic pwm, src;
    pwm = m_ctrl[4*c] && (m_cnt[c] < m_aon[c]);
    src = m_sel[4*c] ? pwm : vf[c];
    return m_ctrl[4*c+2] | src;
  endfunction

  function automatic logic exp_pin(int c);
    return m_ctrl[4*c+3] ? 1'b0 : exp_lvl(c);
  endfunction

  function automatic logic exp_oe(int c);
    if (m_ctrl[4*c+1]) return 1'b0;
    return m_ctrl[4*c+3] ? !exp_lvl(c) : 1'b1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [5:0] a, logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, $sformatf("read 0x%0h", a), rdata, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // input drive and per-cycle comparison (R13: both channels each cycle)
  initial begin
    forever begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        if (tick_div[c] == 0) tick[c] = 1'b0;
        else begin
          tick_ph[c]++;
          if (tick_ph[c] >= tick_div[c]) begin tick_ph[c] = 0; tick[c] = 1'b1; end
          else tick[c] = 1'b0;
        end
      end
      vf_cnt++;
      vf[0] = ((vf_cnt / 5) % 2) != 0;
      vf[1] = ((vf_cnt / 3) % 2) != 0;
      #1;
      if (rst_n && !done) begin
        for (int c = 0; c < 2; c++) begin
          chk(cur_req, $sformatf("ch%0d pin", c), pin[c], exp_pin(c));
          chk(cur_req, $sformatf("ch%0d oe", c), oe[c], exp_oe(c));
        end
        chk(cur_req, "cword", cword, {m_hi[1], m_lo[1], m_hi[0], m_lo[0]});
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 6'h00, 8'h22);
    rd("R1", 6'h04, 8'h00);
    rd("R1", 6'h18, 8'h00);
    rd("R1", 6'h24, 8'h00);
    chk("R1", "oe", oe, 0);
    chk("R1", "cword", cword, 0);

    // R2 map and read back
    cur_req = "R2";
    wr(6'h08, 8'h12); wr(6'h0C, 8'h34); wr(6'h10, 8'h56); wr(6'h14, 8'h78);
    rd("R2", 6'h08, 8'h12); rd("R2", 6'h14, 8'h78);
    #1 chk("R2", "cword", cword, 32'h5678_1234);
    wr(6'h30, 8'hAA);
    rd("R2", 6'h30, 8'h00);
    rd("R2", 6'h01, 8'h00);
    // R3 only select bits stored
    cur_req = "R3";
    wr(6'h04, 8'hFF);
    rd("R3", 6'h04, 8'h11);

    // R4 basic waveform, tick every cycle then every third
    cur_req = "R4";
    tick_div[0] = 1;
    wr(6'h18, 8'd3); wr(6'h1C, 8'd7);
    rd("R4", 6'h1C, 8'd7);
    wr(6'h00, 8'h21);
    wait_cyc(40);
    tick_div[0] = 3;
    wait_cyc(60);

    // R8 reprogram mid-period
    cur_req = "R8";
    tick_div[0] = 1;
    wait_cyc(3);
    wr(6'h18, 8'd6); wr(6'h1C, 8'd9);
    wait_cyc(50);

    // R6 zero high time
    cur_req = "R6";
    wr(6'h18, 8'd0);
    wait_cyc(30);
    chk("R6", "pin0 low", pin[0], 0);

    // R5 high time above period
    cur_req = "R5";
    wr(6'h18, 8'hFF); wr(6'h1C, 8'hFE);
    wait_cyc(300);
    chk("R5", "pin0 high", pin[0], 1);

    // R7 stop and restart
    cur_req = "R7";
    wr(6'h00, 8'h20);
    wait_cyc(4);
    chk("R7", "pin0 stopped", pin[0], 0);
    wr(6'h18, 8'd2); wr(6'h1C, 8'd4);
    wr(6'h00, 8'h21);
    wait_cyc(30);

    // R9 raw source on ch1
    cur_req = "R9";
    wr(6'h04, 8'h01);
    wr(6'h00, 8'h01);
    wait_cyc(20);

    // R10 force high, then force with disable
    cur_req = "R10";
    wr(6'h00, 8'h41);
    wait_cyc(10);
    chk("R10", "pin1 forced", pin[1], 1);
    wr(6'h00, 8'h61);
    wait_cyc(5);
    chk("R10", "oe1 disabled under force", oe[1], 0);

    // R11 open drain on ch1 PWM
    cur_req = "R11";
    tick_div[1] = 2;
    wr(6'h20, 8'd3); wr(6'h24, 8'd5);
    wr(6'h04, 8'h11);
    wr(6'h00, 8'h91);
    wait_cyc(40);
    wr(6'h00, 8'hD1);
    wait_cyc(5);
    chk("R11", "oe1 released when high", oe[1], 0);

    // R12 disable
    cur_req = "R12";
    wr(6'h00, 8'h93);
    wait_cyc(10);
    chk("R12", "oe0 disabled", oe[0], 0);

    // R13 both channels plain push-pull
    cur_req = "R13";
    tick_div[0] = 2; tick_div[1] = 1;
    wr(6'h18, 8'd1); wr(6'h1C, 8'd2);
    wr(6'h00, 8'h11);
    wait_cyc(60);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule